// File: doc/BRIEF.md
# FizzBuzz Serial Text Generator

This block writes the FizzBuzz listing for the integers 1 to 100 as plain ASCII text on a single asynchronous serial line. Each entry is the decimal number, or one of the words Fizz, Buzz or FizzBuzz in place of the number. A carriage return and a line feed close every entry. The text leaves through a built-in transmitter that sends 8N1 frames at a bit period set in clock cycles. The default of 5208 cycles gives 9600 baud from a 50 MHz clock.

Divisibility is tracked by a mod-3 counter and a mod-5 counter that step with the number. The number itself is held as three BCD digits. No divider or multiplier appears anywhere. A character sequencer builds each entry one byte at a time. It passes a new byte to the transmitter only once the stop bit of the previous byte has ended. A single start pulse runs the whole listing. When the last terminator is on the line, the done flag rises and the line rests high.

Top module: `fizzbuzz_tx`

## Requirements
- R1: After reset, `serial_out` is high and `done` is low. No frame is sent until a start pulse arrives.
- R2: Entries cover 1 up to LAST_NUM (default 100) in increasing order. A number that is a multiple of neither 3 nor 5 is printed in decimal with no leading zeros. Each digit is sent as 0x30 plus its value.
- R3: A number that is a multiple of 3 and not of 5 is replaced by the four bytes "Fizz" (0x46 0x69 0x7A 0x7A).
- R4: A multiple of 5 that is not a multiple of 3 is replaced by "Buzz" (0x42 0x75 0x7A 0x7A). A multiple of 15 is replaced by "FizzBuzz".
- R5: Every entry ends with 0x0D followed by 0x0A.
- R6: Each byte goes out as one frame. The frame is a low start bit, then the eight data bits least significant first, then a high stop bit. The line is high whenever no frame is in progress.
- R7: Every bit, start and stop included, holds the line for exactly CLKS_PER_BIT clock cycles (default 5208).
- R8: A new frame begins only after the previous stop bit has completed. Start edges of consecutive frames are therefore at least 10 × CLKS_PER_BIT cycles apart.
- R9: After the stop bit of the final line feed, `done` goes high. From then on the line stays high and `done` stays high until reset or a new start pulse.
- R10: A start pulse that arrives while the listing is being sent is ignored. The text continues unchanged and `done` stays low.
- R11: A start pulse while `done` is high clears `done` and restarts the listing from 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins the listing from 1 |
| serial_out | output | 1 | Asynchronous serial line, idle high |
| done | output | 1 | High once the whole listing has been sent |

## Verification
Two functions can meet in a single cycle. One is the sequencer deciding to load the next byte. The other is the transmitter finishing the stop bit of the current byte. The bench receives the complete listing and measures the spacing of every start edge against the previous one. An early load would either cut a stop bit short or overlap two frames, and the mid-bit sampling would see it as a framing or content error. A start pulse is also injected in the middle of the listing. The bench then confirms that the text after the pulse still matches the reference, which shows that the restart logic did not act on that cycle.

// File: rtl/fb_pkg.sv
package fb_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SEND  = 2'd1,
      SQ_DRAIN = 2'd2,
      SQ_DONE  = 2'd3
   } seq_state_t;

   localparam logic [7:0] ASCII_CR   = 8'h0D;
   localparam logic [7:0] ASCII_LF   = 8'h0A;
   localparam logic [7:0] ASCII_ZERO = 8'h30;

   // letter i of "Fizz" (second word selects "Buzz")
   function automatic logic [7:0] word_char(input logic second, input logic [1:0] i);
      logic [7:0] c;
      case (i)
         2'd0:    c = second ? 8'h42 : 8'h46;
         2'd1:    c = second ? 8'h75 : 8'h69;
         default: c = 8'h7A;
      endcase
      return c;
   endfunction

   // number of printable characters before the line terminator
   function automatic logic [3:0] body_len(input logic fz, input logic bz,
                                           input logic [3:0] hd, input logic [3:0] td);
      if (fz && bz)       return 4'd8;
      else if (fz || bz)  return 4'd4;
      else if (hd != 4'd0) return 4'd3;
      else if (td != 4'd0) return 4'd2;
      else                return 4'd1;
   endfunction

   function automatic logic [7:0] entry_char(input logic fz, input logic bz,
                                             input logic [3:0] hd, input logic [3:0] td,
                                             input logic [3:0] ud, input logic [3:0] idx);
      logic [3:0] blen;
      logic [3:0] pos;
      logic [3:0] dg;
      blen = body_len(fz, bz, hd, td);
      pos  = blen - 4'd1 - idx;
      case (pos)
         4'd0:    dg = ud;
         4'd1:    dg = td;
         default: dg = hd;
      endcase
      if (idx == blen)          return ASCII_CR;
      else if (idx > blen)      return ASCII_LF;
      else if (fz && bz)        return word_char(idx >= 4'd4, idx[1:0]);
      else if (fz || bz)        return word_char(bz, idx[1:0]);
      else                      return ASCII_ZERO + {4'h0, dg};
   endfunction

endpackage

// File: rtl/fb_number.sv
module fb_number #(
   parameter int LAST_NUM = 100
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       init,
   input  logic       step,
   output logic       fizz,
   output logic       buzz,
   output logic [3:0] dig_h,
   output logic [3:0] dig_t,
   output logic [3:0] dig_u,
   output logic       at_last
);
   localparam logic [3:0] LAST_H = 4'(LAST_NUM / 100);
   localparam logic [3:0] LAST_T = 4'((LAST_NUM / 10) % 10);
   localparam logic [3:0] LAST_U = 4'(LAST_NUM % 10);

   logic [1:0] mod3;
   logic [2:0] mod5;

   always_ff @(posedge clk) begin
      if (rst) begin
         mod3  <= 2'd0;
         mod5  <= 3'd0;
         dig_h <= 4'd0;
         dig_t <= 4'd0;
         dig_u <= 4'd0;
      end else if (init) begin
         mod3  <= 2'd1;
         mod5  <= 3'd1;
         dig_h <= 4'd0;
         dig_t <= 4'd0;
         dig_u <= 4'd1;
      end else if (step) begin
         mod3 <= (mod3 == 2'd2) ? 2'd0 : mod3 + 2'd1;
         mod5 <= (mod5 == 3'd4) ? 3'd0 : mod5 + 3'd1;
         if (dig_u != 4'd9) begin
            dig_u <= dig_u + 4'd1;
         end else begin
            dig_u <= 4'd0;
            if (dig_t != 4'd9) begin
               dig_t <= dig_t + 4'd1;
            end else begin
               dig_t <= 4'd0;
               dig_h <= dig_h + 4'd1;
            end
         end
      end
   end

   assign fizz    = (mod3 == 2'd0);
   assign buzz    = (mod5 == 3'd0);
   assign at_last = (dig_h == LAST_H) && (dig_t == LAST_T) && (dig_u == LAST_U);
endmodule

// File: rtl/fb_uart_tx.sv
module fb_uart_tx #(
   parameter int CLKS_PER_BIT = 5208
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [7:0] data,
   output logic       busy,
   output logic       line
);
   localparam int             CW       = $clog2(CLKS_PER_BIT);
   localparam logic [CW-1:0]  CNT_LAST = CW'(CLKS_PER_BIT - 1);
   localparam logic [3:0]     ST_START = 4'd0;
   localparam logic [3:0]     ST_STOP  = 4'd9;

   logic [CW-1:0] bit_cnt;
   logic [3:0]    bit_st;
   logic [7:0]    shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         bit_st  <= ST_START;
         bit_cnt <= '0;
         shreg   <= 8'h00;
      end else if (!busy) begin
         if (load) begin
            busy    <= 1'b1;
            shreg   <= data;
            bit_st  <= ST_START;
            bit_cnt <= '0;
         end
      end else if (bit_cnt == CNT_LAST) begin
         bit_cnt <= '0;
         if (bit_st == ST_STOP) begin
            busy <= 1'b0;
         end else begin
            if (bit_st != ST_START) shreg <= shreg >> 1;
            bit_st <= bit_st + 4'd1;
         end
      end else begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_comb begin
      if (!busy)                 line = 1'b1;
      else if (bit_st == ST_START) line = 1'b0;
      else if (bit_st == ST_STOP)  line = 1'b1;
      else                       line = shreg[0];
   end
endmodule

// File: rtl/fb_seq.sv
module fb_seq
   import fb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       fizz,
   input  logic       buzz,
   input  logic [3:0] dig_h,
   input  logic [3:0] dig_t,
   input  logic [3:0] dig_u,
   input  logic       at_last,
   input  logic       tx_busy,
   output logic       num_init,
   output logic       num_step,
   output logic       tx_load,
   output logic [7:0] tx_data,
   output logic       done
);
   seq_state_t st;
   logic [3:0] idx;
   logic       last_char;

   assign last_char = (idx == body_len(fizz, buzz, dig_h, dig_t) + 4'd1);
   assign tx_data   = entry_char(fizz, buzz, dig_h, dig_t, dig_u, idx);
   assign tx_load   = (st == SQ_SEND) && !tx_busy;
   assign num_init  = start && ((st == SQ_IDLE) || (st == SQ_DONE));
   assign num_step  = tx_load && last_char && !at_last;
   assign done      = (st == SQ_DONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= SQ_IDLE;
         idx <= 4'd0;
      end else begin
         case (st)
            SQ_IDLE, SQ_DONE: begin
               if (start) begin
                  st  <= SQ_SEND;
                  idx <= 4'd0;
               end
            end
            SQ_SEND: begin
               if (tx_load) begin
                  if (last_char) begin
                     idx <= 4'd0;
                     if (at_last) st <= SQ_DRAIN;
                  end else begin
                     idx <= idx + 4'd1;
                  end
               end
            end
            default: begin
               if (!tx_busy) st <= SQ_DONE;
            end
         endcase
      end
   end
endmodule

// File: rtl/fizzbuzz_tx.sv
module fizzbuzz_tx #(
   parameter int CLKS_PER_BIT = 5208,
   parameter int LAST_NUM     = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic serial_out,
   output logic done
);
   generate
      if (CLKS_PER_BIT < 2) begin : g_bad_div
         $error("CLKS_PER_BIT must be at least 2");
      end
      if (LAST_NUM < 1 || LAST_NUM > 999) begin : g_bad_last
         $error("LAST_NUM must lie in 1..999");
      end
   endgenerate

   logic       fizz, buzz, at_last;
   logic [3:0] dig_h, dig_t, dig_u;
   logic       num_init, num_step;
   logic       tx_load, tx_busy;
   logic [7:0] tx_data;

   fb_number #(.LAST_NUM(LAST_NUM)) u_num (
      .clk(clk), .rst(rst), .init(num_init), .step(num_step),
      .fizz(fizz), .buzz(buzz), .dig_h(dig_h), .dig_t(dig_t), .dig_u(dig_u),
      .at_last(at_last)
   );

   fb_seq u_seq (
      .clk(clk), .rst(rst), .start(start),
      .fizz(fizz), .buzz(buzz), .dig_h(dig_h), .dig_t(dig_t), .dig_u(dig_u),
      .at_last(at_last), .tx_busy(tx_busy),
      .num_init(num_init), .num_step(num_step),
      .tx_load(tx_load), .tx_data(tx_data), .done(done)
   );

   fb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
      .clk(clk), .rst(rst), .load(tx_load), .data(tx_data),
      .busy(tx_busy), .line(serial_out)
   );
endmodule

// File: rtl/fizzbuzz_tx_checker.sv
module fizzbuzz_tx_checker #(
   parameter int CLKS_PER_BIT = 5208
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic serial_out,
   input logic done,
   input logic tx_busy
);
   int unsigned low_run;

   always_ff @(posedge clk) begin
      if (rst)                low_run <= 0;
      else if (!serial_out)   low_run <= low_run + 1;
      else                    low_run <= 0;
   end

   // R6: a frame begins with a low start bit
   p_start_low_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_busy) |-> !serial_out);

   // R7: every low stretch inside a frame is a whole number of bit periods
   p_bit_width_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(serial_out) |-> ((low_run % CLKS_PER_BIT) == 0));

   // R9: finished means quiet line
   p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> (serial_out && !tx_busy));

   // R9: done is held until a new start
   p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

   // R11: a start while finished clears done
   p_restart_r11: assert property (@(posedge clk) disable iff (rst)
      (done && start) |=> !done);
endmodule

bind fizzbuzz_tx fizzbuzz_tx_checker #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
   .clk(clk), .rst(rst), .start(start), .serial_out(serial_out),
   .done(done), .tx_busy(tx_busy)
);

// File: tb/fizzbuzz_tx_test.sv
module fizzbuzz_tx_test;
   localparam int CLK_PERIOD = 10;
   localparam int BIT        = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic serial_out, done;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit finished = 0;

   logic [7:0] ref_b[$];
   string      ref_tag[$];

   // per-frame results of the receiver
   logic [7:0] rx_data;
   logic       rx_start_ok, rx_stop_ok, rx_lo_last, rx_hi_first;
   int         rx_edge;

   fizzbuzz_tx #(.CLKS_PER_BIT(BIT), .LAST_NUM(100)) uut (
      .clk(clk), .rst(rst), .start(start), .serial_out(serial_out), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void build_ref();
      for (int n = 1; n <= 100; n++) begin
         string s;
         string tg;
         if (n % 15 == 0)     begin s = "FizzBuzz"; tg = "R4"; end
         else if (n % 3 == 0) begin s = "Fizz";     tg = "R3"; end
         else if (n % 5 == 0) begin s = "Buzz";     tg = "R4"; end
         else                 begin s = $sformatf("%0d", n); tg = "R2"; end
         for (int i = 0; i < s.len(); i++) begin
            ref_b.push_back(8'(s[i]));
            ref_tag.push_back(tg);
         end
         ref_b.push_back(8'h0D); ref_tag.push_back("R5");
         ref_b.push_back(8'h0A); ref_tag.push_back("R5");
      end
   endfunction

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   // waits for a start edge, then samples every bit at its middle
   task automatic rx_byte();
      @(negedge clk);
      while (serial_out !== 1'b0) @(negedge clk);
      rx_edge = cyc;
      rx_data = 8'h00;
      for (int i = 1; i <= 9*BIT + BIT/2; i++) begin
         @(negedge clk);
         if (i == BIT/2)   rx_start_ok = (serial_out == 1'b0);
         if (i == BIT - 1) rx_lo_last  = (serial_out == 1'b0);
         if (i == BIT)     rx_hi_first = serial_out;
         if (i >= BIT + BIT/2 && i < 9*BIT && ((i - BIT/2) % BIT) == 0)
            rx_data[(i - BIT/2)/BIT - 1] = serial_out;
         if (i == 9*BIT + BIT/2) rx_stop_ok = serial_out;
      end
   endtask

   task automatic test_reset();
      int lows = 0;
      @(negedge clk);
      check_eq("R1", "line after reset", int'(serial_out), 1);
      check_eq("R1", "done after reset", int'(done), 0);
      for (int i = 0; i < 4*BIT; i++) begin
         @(negedge clk);
         if (serial_out !== 1'b1) lows++;
      end
      check_eq("R1", "low samples without start", lows, 0);
   endtask

   task automatic test_full_run();
      int n = ref_b.size();
      int frame_err = 0, gap_err = 0, late_bad = 0, pulse_at = 60;
      int prev_edge = 0;
      int done_mid = 0;
      pulse_start();
      fork
         begin
            for (int k = 0; k < n; k++) begin
               rx_byte();
               if (!rx_start_ok || !rx_stop_ok) frame_err++;
               if (k > 0 && (rx_edge - prev_edge) < 10*BIT) gap_err++;
               prev_edge = rx_edge;
               if (k == 0) begin
                  check_eq("R7", "start bit low in its last cycle", int'(rx_lo_last), 1);
                  check_eq("R7", "first data bit after exactly one period", int'(rx_hi_first), 1);
               end
               if (rx_data != ref_b[k]) begin
                  if (k > pulse_at) late_bad++;
                  check_eq(ref_tag[k], $sformatf("byte %0d", k), int'(rx_data), int'(ref_b[k]));
               end else begin
                  n_tests++;
               end
            end
         end
         begin
            repeat (pulse_at * 10 * BIT) @(posedge clk);
            pulse_start();
            @(negedge clk);
            done_mid = done;
         end
      join
      check_eq("R6", "framing errors", frame_err, 0);
      check_eq("R8", "frames spaced closer than ten bit periods", gap_err, 0);
      check_eq("R10", "done after mid-run start", done_mid, 0);
      check_eq("R10", "mismatched bytes after mid-run start", late_bad, 0);
      check_eq("R2", "byte count", n, 513);
      repeat (BIT + 3) @(negedge clk);
      check_eq("R9", "done after final frame", int'(done), 1);
      begin
         int bad = 0;
         for (int i = 0; i < 5*BIT; i++) begin
            @(negedge clk);
            if (serial_out !== 1'b1 || done !== 1'b1) bad++;
         end
         check_eq("R9", "line or done moved while finished", bad, 0);
      end
   endtask

   task automatic test_restart();
      logic [7:0] exp3 [3] = '{8'h31, 8'h0D, 8'h0A};
      pulse_start();
      check_eq("R11", "done cleared by new start", int'(done), 0);
      for (int k = 0; k < 3; k++) begin
         rx_byte();
         check_eq("R11", $sformatf("restart byte %0d", k), int'(rx_data), int'(exp3[k]));
      end
   endtask

   initial begin
      build_ref();
      repeat (5) @(negedge clk);
      rst = 1'b0;
      test_reset();
      test_full_run();
      test_restart();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule